// File: doc/BRIEF.md
# SMBus Register Access Slave

This block is a two-wire serial slave that lets a bus host read and write a bank of byte-wide registers kept outside the block. It watches the already synchronized SCL and SDA lines on a fast system clock. It finds start, repeated start and stop conditions, checks the 7-bit device address and answers on SDA through an open-drain pull-down enable. It reaches the register bank through a single write port and a combinational read port.

The host first sets an internal register pointer with a one-byte command. It can then write one register, read the register at the pointer, or move a block of bytes. A block write is selected by a reserved command code. Its bytes are held in a staging buffer and are copied into the bank only after the trailing CRC-8 check byte matches. A block read returns consecutive registers and then a CRC-8 check byte. The block length comes from a byte-count input that the surrounding logic takes from a configuration register field.

Top module: `smb_reg_slave`

## Requirements
- R1: After a start condition, the first 8 bits are 7 address bits (MSB first) and a direction bit (0 = write, 1 = read). When the address equals DEV_ADDR (default 0x5C), the slave pulls SDA low during the ninth clock.
- R2: For any other address, the slave does not pull SDA low and ignores all further bytes until the next start condition. No register is written.
- R3: A write transaction made of the address byte, one command byte other than 0xA0, and a stop loads the command byte into the register pointer and writes no register.
- R4: In a write transaction the byte after the command is written to the register at the command's address, and it is acknowledged. Any later byte in the same transaction gets no acknowledge and is not written.
- R5: A read transaction returns the register at the pointer as its first byte. Reads never move the pointer, so repeated receive-byte reads return the same register.
- R6: A repeated start carrying a read address, sent right after a pointer-setting write with no stop between them, is accepted and returns the newly addressed register.
- R7: Command 0xA0 selects block write. The next N data bytes are each acknowledged and land in registers pointer, pointer+1, … pointer+N-1, written in consecutive clock cycles with addresses rising by one.
- R8: N equals blk_len_i when that value is 1 to 32. A value of 0 or above 32 gives N = 32.
- R9: The check byte is a CRC-8 with polynomial 0x07, initial value 0x00 and MSB first, taken over every byte of the transaction including the address byte. After a block write's N data bytes, a matching check byte is acknowledged and the staged bytes are committed. A mismatching one is not acknowledged and no register changes.
- R10: A block read sends registers pointer+k for k = 0 … N-1 for as long as the master acknowledges. Next it sends the CRC-8 over the read address byte and those data bytes. Any further bytes are 0xFF. A master NACK makes the slave release SDA for the rest of the transaction.
- R11: A start or stop condition in the middle of a byte ends the transaction, releases SDA and discards any staged block data. The slave then accepts a new transaction.
- R12: Out of reset, SDA is released and no write is issued. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized SCL line level |
| sda_i | input | 1 | Synchronized SDA line level (resolved bus) |
| blk_len_i | input | 6 | Block byte count from the configuration field |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 8 | Register write address |
| wr_data_o | output | 8 | Register write data |
| rd_addr_o | output | 8 | Register read address (pointer plus read offset) |
| rd_data_i | input | 8 | Register read data for rd_addr_o, same cycle |

## Verification
The hardest cases to reach are those where staged block data must be thrown away: a check byte that is off by a single bit, and a stop that cuts into a data byte after some bytes of the block have already been acknowledged. The bench sends these as complete bus sequences. It flips one bit of a correctly computed CRC, and it stops after three bits of the third data byte. It then compares the whole register model with its expected copy, so that a stray commit anywhere is caught. The length cap is tested by running full 32-byte block transfers with the count field set to 0 and then to 40.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK,
        S_WAIT
    } state_e;

    typedef enum logic [2:0] {
        K_ADDR,
        K_CMD,
        K_DATA,
        K_EXTRA,
        K_BLK,
        K_PEC,
        K_RD
    } kind_e;

    // CRC-8, polynomial x^8+x^2+x+1, MSB first
    function automatic logic [7:0] crc8_next(input logic [7:0] crc, input logic [7:0] b);
        logic [7:0] r;
        r = crc ^ b;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smb_stage_buf.sv
module smb_stage_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h5C,
    parameter int         MAX_BLK  = 32,
    parameter logic [7:0] BLK_CMD  = 8'hA0,
    localparam int        CW       = $clog2(MAX_BLK + 2),
    localparam int        IW       = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [CW-1:0] blk_len_i,
    output logic          sda_oe_o,
    output logic          wr_en_o,
    output logic [7:0]    wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic [7:0]    rd_addr_o,
    input  logic [7:0]    rd_data_i
);
    typedef struct packed {
        state_e        st;
        kind_e         kind;
        logic [3:0]    bits;
        logic [7:0]    sh;
        logic [7:0]    ptr;
        logic [CW-1:0] off;
        logic [CW-1:0] n;
        logic [7:0]    crc;
        logic          oe;
        logic          mack;
        logic          commit;
        logic [CW-1:0] cidx;
        logic          wr_en;
        logic [7:0]    wr_addr;
        logic [7:0]    wr_data;
    } regs_t;

    regs_t q, d;

    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic          buf_we;
    logic [7:0]    buf_rdata;
    logic [CW-1:0] n_eff;

    smb_line_mon i_line_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    smb_stage_buf #(.DEPTH(MAX_BLK), .W(8)) i_stage_buf (
        .clk     (clk),
        .we_i    (buf_we),
        .waddr_i (q.off[IW-1:0]),
        .wdata_i (q.sh),
        .raddr_i (q.cidx[IW-1:0]),
        .rdata_o (buf_rdata)
    );

    assign n_eff = (blk_len_i == '0 || blk_len_i > CW'(MAX_BLK)) ? CW'(MAX_BLK) : blk_len_i;

    always_comb begin
        logic [7:0]    b;
        logic [7:0]    tx_b;
        logic [7:0]    tx_c;
        logic [7:0]    sh_n;
        logic [CW-1:0] off_inc;

        d      = q;
        d.wr_en = 1'b0;
        buf_we = 1'b0;
        b      = q.sh;
        sh_n   = {q.sh[6:0], 1'b0};

        // next byte to send on a read
        if (q.off < q.n) begin
            tx_b = rd_data_i;
            tx_c = crc8_next(q.crc, rd_data_i);
        end else if (q.off == q.n) begin
            tx_b = q.crc;
            tx_c = q.crc;
        end else begin
            tx_b = 8'hFF;
            tx_c = q.crc;
        end
        off_inc = (q.off <= q.n) ? q.off + CW'(1) : q.off;

        // commit of staged block, one register per cycle
        if (q.commit) begin
            d.wr_en   = 1'b1;
            d.wr_addr = q.ptr + 8'(q.cidx);
            d.wr_data = buf_rdata;
            if (q.cidx + CW'(1) == q.n) begin
                d.commit = 1'b0;
            end else begin
                d.cidx = q.cidx + CW'(1);
            end
        end

        if (bus_start) begin
            d.st   = S_RX;
            d.kind = K_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
            d.crc  = '0;
        end else if (bus_stop) begin
            d.st = S_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                S_RX: begin
                    if (scl_rise && q.bits < 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_i};
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        d.bits = '0;
                        d.st   = S_WAIT;
                        unique case (q.kind)
                            K_ADDR: begin
                                d.crc = crc8_next(q.crc, b);
                                if (b[7:1] == DEV_ADDR) begin
                                    d.oe   = 1'b1;
                                    d.st   = S_ACK;
                                    d.n    = n_eff;
                                    d.off  = '0;
                                    d.kind = b[0] ? K_RD : K_CMD;
                                end
                            end
                            K_CMD: begin
                                d.crc = crc8_next(q.crc, b);
                                d.oe  = 1'b1;
                                d.st  = S_ACK;
                                d.off = '0;
                                if (b == BLK_CMD) begin
                                    d.kind = K_BLK;
                                end else begin
                                    d.ptr  = b;
                                    d.kind = K_DATA;
                                end
                            end
                            K_DATA: begin
                                d.wr_en   = 1'b1;
                                d.wr_addr = q.ptr;
                                d.wr_data = b;
                                d.oe      = 1'b1;
                                d.st      = S_ACK;
                                d.kind    = K_EXTRA;
                            end
                            K_BLK: begin
                                d.crc  = crc8_next(q.crc, b);
                                buf_we = 1'b1;
                                d.off  = q.off + CW'(1);
                                d.oe   = 1'b1;
                                d.st   = S_ACK;
                                if (q.off + CW'(1) == q.n) begin
                                    d.kind = K_PEC;
                                end
                            end
                            K_PEC: begin
                                if (b == q.crc) begin
                                    d.oe     = 1'b1;
                                    d.st     = S_ACK;
                                    d.commit = 1'b1;
                                    d.cidx   = '0;
                                    d.kind   = K_EXTRA;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        d.bits = '0;
                        if (q.kind == K_RD) begin
                            d.sh  = tx_b;
                            d.crc = tx_c;
                            d.off = off_inc;
                            d.oe  = ~tx_b[7];
                            d.st  = S_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = S_RX;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.bits == 4'd7) begin
                            d.oe = 1'b0;
                            d.st = S_MACK;
                        end else begin
                            d.sh   = sh_n;
                            d.oe   = ~sh_n[7];
                            d.bits = q.bits + 4'd1;
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_i;
                    end else if (scl_fall) begin
                        d.bits = '0;
                        if (q.mack) begin
                            d.sh  = tx_b;
                            d.crc = tx_c;
                            d.off = off_inc;
                            d.oe  = ~tx_b[7];
                            d.st  = S_TX;
                        end else begin
                            d.st = S_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= S_IDLE;
            q.kind    <= K_ADDR;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.oe;
    assign wr_en_o   = q.wr_en;
    assign wr_addr_o = q.wr_addr;
    assign wr_data_o = q.wr_data;
    assign rd_addr_o = q.ptr + 8'(q.off);
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
    parameter int MAX_BLK = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_oe_o,
    input logic       wr_en_o,
    input logic [7:0] wr_addr_o
);
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= wr_en_o ? run_q + 8'd1 : 8'd0;
        end
    end

    // R12
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_i));

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe_o);

    // R7
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 8'd1));

    // R8
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (32'(run_q) < MAX_BLK));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.MAX_BLK(MAX_BLK)) i_smb_reg_slave_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o)
);

// File: tb/test_smb_reg_slave.sv
module test_smb_reg_slave;
    localparam int Q = 5;
    localparam logic [7:0] AW = 8'hB8;
    localparam logic [7:0] AR = 8'hB9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [5:0] blk_len = 6'd4;
    logic       sda_oe, wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic       sda_line;
    logic [7:0] regs [256];
    logic [7:0] exp_m [256];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);
    assign rd_data  = regs[rd_addr];

    smb_reg_slave i_smb_reg_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .blk_len_i (blk_len),
        .sda_oe_o  (sda_oe),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data)
    );

    function automatic logic [7:0] init_val(input logic [7:0] a);
        return (a * 8'd7) + 8'd3;
    endfunction

    function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) regs[i] <= init_val(8'(i));
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic mem_chk(input string req);
        int bad = 0;
        int where = -1;
        for (int i = 0; i < 256; i++) begin
            if (regs[i] !== exp_m[i]) begin
                bad++;
                if (where < 0) where = i;
            end
        end
        chk(bad == 0, req, where < 0 ? 0 : int'(regs[where]), where < 0 ? 0 : int'(exp_m[where]));
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start();
        m_low = 1'b0; wt(Q); scl = 1'b1; wt(Q); m_low = 1'b1; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic b_stop();
        m_low = 1'b1; wt(Q); scl = 1'b1; wt(Q); m_low = 1'b0; wt(4 * Q);
    endtask

    task automatic s_bit(input logic v);
        m_low = ~v; wt(Q); scl = 1'b1; wt(2 * Q); scl = 1'b0; wt(Q);
    endtask

    task automatic r_bit(output logic v);
        m_low = 1'b0; wt(Q); scl = 1'b1; wt(Q); v = sda_line; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic s_byte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) s_bit(v[i]);
        r_bit(x);
        ack = ~x;
    endtask

    task automatic r_byte(output logic [7:0] v, input logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            r_bit(x);
            v[i] = x;
        end
        s_bit(~ack);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R12 released after reset", sda_oe, 0);
        chk(wr_en == 1'b0, "R12 no write after reset", wr_en, 0);
        mem_chk("R12 bank untouched");
    endtask

    task automatic t_write_byte();
        logic a0, a1, a2, a3;
        b_start(); s_byte(AW, a0); s_byte(8'h10, a1); s_byte(8'h33, a2); b_stop();
        exp_m[8'h10] = 8'h33;
        chk(a0, "R1 address ack", a0, 1);
        chk(a1 && a2, "R4 command/data ack", {a1, a2}, 3);
        mem_chk("R4 write byte stored");
        b_start(); s_byte(AW, a0); s_byte(8'h11, a1); s_byte(8'h44, a2); s_byte(8'h55, a3); b_stop();
        exp_m[8'h11] = 8'h44;
        chk(!a3, "R4 extra byte nack", a3, 0);
        mem_chk("R4 extra byte not written");
    endtask

    task automatic t_send_recv();
        logic a0, a1;
        logic [7:0] v;
        b_start(); s_byte(AW, a0); s_byte(8'h10, a1); b_stop();
        mem_chk("R3 send byte writes nothing");
        for (int k = 0; k < 2; k++) begin
            b_start(); s_byte(AR, a0); r_byte(v, 1'b0); b_stop();
            chk(a0, "R1 read address ack", a0, 1);
            chk(v == exp_m[8'h10], "R5 receive byte at pointer", v, exp_m[8'h10]);
        end
    endtask

    task automatic t_rep_start();
        logic a0, a1, a2;
        logic [7:0] v;
        b_start(); s_byte(AW, a0); s_byte(8'h20, a1); b_start(); s_byte(AR, a2); r_byte(v, 1'b0); b_stop();
        chk(a2, "R6 repeated start ack", a2, 1);
        chk(v == exp_m[8'h20], "R6 repeated start data", v, exp_m[8'h20]);
    endtask

    task automatic t_bad_addr();
        logic a0, a1, a2;
        b_start(); s_byte(8'h44, a0); s_byte(8'h21, a1); s_byte(8'h99, a2); b_stop();
        chk(!a0, "R2 foreign address nack", a0, 0);
        chk(!a1 && !a2, "R2 later bytes ignored", {a1, a2}, 0);
        mem_chk("R2 no write");
    endtask

    task automatic blk_write(input logic [7:0] ptr, input int n, input int seed,
                             input bit corrupt, output bit all_ack, output logic pec_ack);
        logic a;
        logic [7:0] c;
        logic [7:0] dv;
        b_start(); s_byte(AW, a); s_byte(ptr, a); b_stop();
        all_ack = 1'b1;
        b_start();
        s_byte(AW, a); all_ack &= a; c = crc_upd(8'h00, AW);
        s_byte(8'hA0, a); all_ack &= a; c = crc_upd(c, 8'hA0);
        for (int k = 0; k < n; k++) begin
            dv = 8'(seed + k * 13);
            s_byte(dv, a); all_ack &= a; c = crc_upd(c, dv);
            if (!corrupt) exp_m[8'(ptr + 8'(k))] = dv;
        end
        s_byte(corrupt ? (c ^ 8'h01) : c, pec_ack);
        b_stop();
        wt(40);
    endtask

    task automatic t_block_write();
        bit ok;
        logic pa;
        blk_len = 6'd4;
        blk_write(8'h40, 4, 8'h21, 1'b0, ok, pa);
        chk(ok, "R7 block data ack", ok, 1);
        chk(pa, "R9 good PEC ack", pa, 1);
        mem_chk("R7 block committed");
        blk_write(8'h50, 4, 8'h90, 1'b1, ok, pa);
        chk(!pa, "R9 bad PEC nack", pa, 0);
        mem_chk("R9 bad PEC no commit");
    endtask

    task automatic t_abort();
        logic a;
        b_start(); s_byte(AW, a); s_byte(8'h60, a); b_stop();
        b_start(); s_byte(AW, a); s_byte(8'hA0, a); s_byte(8'h01, a); s_byte(8'h02, a);
        s_bit(1'b1); s_bit(1'b0); s_bit(1'b1);
        b_stop(); wt(40);
        chk(sda_oe == 1'b0, "R11 released after abort", sda_oe, 0);
        mem_chk("R11 staged data discarded");
        b_start(); s_byte(AW, a); s_byte(8'h61, a); s_byte(8'h77, a); b_stop();
        exp_m[8'h61] = 8'h77;
        chk(a, "R11 recovers after abort", a, 1);
        mem_chk("R11 write after abort");
    endtask

    task automatic blk_read(input logic [7:0] ptr, input int n, input string req);
        logic a;
        logic [7:0] v;
        logic [7:0] c;
        int bad = 0;
        b_start(); s_byte(AW, a); s_byte(ptr, a);
        b_start(); s_byte(AR, a); c = crc_upd(8'h00, AR);
        for (int k = 0; k < n; k++) begin
            r_byte(v, 1'b1);
            if (v !== exp_m[8'(ptr + 8'(k))]) begin
                bad++;
                $display("FAIL %s byte %0d actual=0x%0h expected=0x%0h", req, k, v, exp_m[8'(ptr + 8'(k))]);
            end
            c = crc_upd(c, v);
        end
        n_chk++;
        if (bad != 0) n_fail++;
        r_byte(v, 1'b0);
        chk(v == c, {req, " read PEC"}, v, c);
        wt(2);
        chk(sda_oe == 1'b0, "R10 released after nack", sda_oe, 0);
        b_stop();
    endtask

    task automatic t_block_read();
        blk_len = 6'd5;
        blk_read(8'h3E, 5, "R10 block read");
    endtask

    task automatic t_count_cap();
        bit ok;
        logic pa;
        blk_len = 6'd0;
        blk_write(8'h80, 32, 8'h05, 1'b0, ok, pa);
        chk(ok && pa, "R8 zero count gives 32", {ok, pa}, 3);
        mem_chk("R8 32 bytes committed");
        blk_len = 6'd40;
        blk_read(8'h80, 32, "R8 capped read");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_m[i] = init_val(8'(i));
        wt(6);
        rst_n = 1'b1;
        wt(4);
        t_reset();
        t_write_byte();
        t_send_recv();
        t_rep_start();
        t_bad_addr();
        t_block_write();
        t_abort();
        t_block_read();
        t_count_cap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule